// File: doc/BRIEF.md
# Byte-Indexed Bit Gather Unit

This combinational unit builds a 64-bit result from two 64-bit operands. In gather mode, the index operand is split into eight 8-bit lanes. Each lane names one bit of the source operand, and that bit is placed at the lane's position in the low byte of the result. The source is numbered from its most significant end, so index 0 selects source bit 63. An index that points past the last source bit yields a zero.

In compare mode, the same two operands are compared byte by byte. Each result byte is set to all ones where the two bytes match and to all zeros where they differ. A single select input chooses which of the two results appears at the output. The output follows the inputs with no register in between.

Top module: `bperm_unit`

## Requirements
- R1: Lane k of the gather (k = 0..7) takes its index from idx_i[8k+7:8k] and drives res_o[k].
- R2: In gather mode, for an index v below 64, res_o[k] equals src_i[63 - v]. Index 0 therefore selects src_i[63] and index 63 selects src_i[0].
- R3: In gather mode, any index of 64 or more (64 to 255) forces its result bit to 0, whatever the source holds.
- R4: In gather mode, res_o[63:8] is always 0.
- R5: In compare mode, result byte k (res_o[8k+7:8k]) is 8'hFF when idx_i and src_i are equal in byte k, and 8'h00 otherwise.
- R6: mode_i = 0 selects the gather result and mode_i = 1 selects the compare result. The output responds combinationally to every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 1 | 0 = bit gather, 1 = byte compare |
| idx_i | input | 64 | Eight 8-bit gather indices; first compare operand |
| src_i | input | 64 | Source word for the gather; second compare operand |
| res_o | output | 64 | Selected result |

## Verification
The gather is driven with the index values 0, 63, 64 and 255 in every lane, mixed with random source words. These values separate an off-by-one or reversed bit numbering from a correct one, and show whether the range check cuts off at exactly 64. Fully random index words mostly land out of range, so separate random indices limited to 0..63 exercise the bit selection itself. Compare mode is tried with identical operands, with operands that differ in every byte, and with operands where a chosen subset of bytes has been altered. These cases reveal swapped bytes or a compare whose result spreads into the wrong byte.

// File: rtl/bperm_pkg.sv
package bperm_pkg;
  typedef enum logic {
    MODE_GATHER = 1'b0,
    MODE_CMP    = 1'b1
  } bpu_mode_e;
endpackage

// File: rtl/bperm_lane.sv
module bperm_lane #(
  parameter int SRC_W = 64,
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [SRC_W-1:0] src_i,
  output logic             bit_o
);
  localparam int SEL_W = $clog2(SRC_W);

  logic [SRC_W-1:0] rev;
  logic             in_range;

  // index 0 addresses the most significant source bit
  always_comb begin
    for (int k = 0; k < SRC_W; k++) rev[k] = src_i[SRC_W-1-k];
  end

  assign in_range = ~|(idx_i >> SEL_W);
  assign bit_o    = in_range & rev[idx_i[SEL_W-1:0]];

  always_comb begin
    if (int'(idx_i) >= SRC_W) begin
      assert_oor_zero_R3: assert (bit_o == 1'b0)
        else $error("out-of-range index produced a one");
    end else begin
      assert_msb_first_R2: assert (bit_o == src_i[SRC_W-1-int'(idx_i)])
        else $error("selected bit does not match source");
    end
  end
endmodule

// File: rtl/bperm_bytecmp.sv
module bperm_bytecmp #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] mask_o
);
  localparam int N_LANE = DATA_W / LANE_W;

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    logic hit;
    assign hit = (a_i[g*LANE_W +: LANE_W] == b_i[g*LANE_W +: LANE_W]);
    assign mask_o[g*LANE_W +: LANE_W] = {LANE_W{hit}};

    always_comb begin
      assert_byte_uniform_R5: assert (mask_o[g*LANE_W +: LANE_W] == '0 ||
                                      mask_o[g*LANE_W +: LANE_W] == '1)
        else $error("compare byte not uniform");
    end
  end
endmodule

// File: rtl/bperm_unit.sv
module bperm_unit #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic              mode_i,
  input  logic [DATA_W-1:0] idx_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] res_o
);
  import bperm_pkg::*;

  localparam int N_LANE = DATA_W / LANE_W;

  bpu_mode_e         mode;
  logic [N_LANE-1:0] gather_bits;
  logic [DATA_W-1:0] gather_word;
  logic [DATA_W-1:0] cmp_word;

  assign mode = bpu_mode_e'(mode_i);

  for (genvar g = 0; g < N_LANE; g++) begin : g_gather
    bperm_lane #(.SRC_W(DATA_W), .IDX_W(LANE_W)) u_lane (
      .idx_i (idx_i[g*LANE_W +: LANE_W]),
      .src_i (src_i),
      .bit_o (gather_bits[g])
    );
  end

  assign gather_word = {{(DATA_W-N_LANE){1'b0}}, gather_bits};

  bperm_bytecmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
    .a_i    (idx_i),
    .b_i    (src_i),
    .mask_o (cmp_word)
  );

  assign res_o = (mode == MODE_CMP) ? cmp_word : gather_word;

  always_comb begin
    if (mode == MODE_GATHER) begin
      assert_upper_clear_R4: assert (res_o[DATA_W-1:N_LANE] == '0)
        else $error("gather result has upper bits set");
    end
    if (mode == MODE_CMP && idx_i == src_i) begin
      assert_equal_all_ones_R5: assert (res_o == '1)
        else $error("equal operands did not give all ones");
    end
  end
endmodule

// File: tb/sim_bperm_unit.sv
module sim_bperm_unit;
  logic        clk = 1'b0;
  logic        mode;
  logic [63:0] idx, src, res;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  bperm_unit u0 (.mode_i(mode), .idx_i(idx), .src_i(src), .res_o(res));

  function automatic logic [63:0] ref_gather(input logic [63:0] ix, input logic [63:0] s);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) begin
      int v = int'(ix[8*k +: 8]);
      r[k] = (v < 64) ? s[63 - v] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [63:0] ref_cmp(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    for (int k = 0; k < 8; k++)
      r[8*k +: 8] = (a[8*k +: 8] == b[8*k +: 8]) ? 8'hFF : 8'h00;
    return r;
  endfunction

  task automatic apply(input logic m, input logic [63:0] ix, input logic [63:0] s,
                       input string req);
    logic [63:0] exp;
    @(posedge clk);
    #1;
    mode = m; idx = ix; src = s;
    @(negedge clk);
    exp = m ? ref_cmp(ix, s) : ref_gather(ix, s);
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s mode=%0d idx=%h src=%h actual=%h expected=%h",
               req, m, ix, s, res, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    void'($urandom(32'd1357));
    mode = 1'b0; idx = '0; src = '0;
    // zero inputs: gather reads src[63]=0 everywhere
    apply(1'b0, 64'h0, 64'h0, "R4 reset-like zero");
    // index 0 selects msb, index 63 selects lsb
    apply(1'b0, 64'h0, 64'h8000_0000_0000_0000, "R2 index 0 msb");
    apply(1'b0, {8{8'd63}}, 64'h1, "R2 index 63 lsb");
    apply(1'b0, {8{8'd63}}, 64'h8000_0000_0000_0000, "R2 index 63 not msb");
    // range boundary
    apply(1'b0, {8{8'd64}}, '1, "R3 index 64");
    apply(1'b0, {8{8'd255}}, '1, "R3 index 255");
    apply(1'b0, {8'd255, 8'd0, 8'd64, 8'd63, 8'd64, 8'd0, 8'd255, 8'd63}, '1,
          "R1 mixed lanes");
    // distinct lane indices: lane k selects bit 63-k
    apply(1'b0, {8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0},
          64'hA500_0000_0000_0000, "R1 lane order");
    for (int n = 0; n < 40; n++) begin
      logic [63:0] ix;
      for (int k = 0; k < 8; k++) begin
        case ($urandom_range(3))
          0: ix[8*k +: 8] = 8'd0;
          1: ix[8*k +: 8] = 8'd63;
          2: ix[8*k +: 8] = 8'd64;
          default: ix[8*k +: 8] = 8'd255;
        endcase
      end
      apply(1'b0, ix, rnd64(), "R3 corner indices random src");
    end
    for (int n = 0; n < 60; n++) begin
      logic [63:0] ix;
      for (int k = 0; k < 8; k++) ix[8*k +: 8] = 8'($urandom_range(63));
      apply(1'b0, ix, rnd64(), "R2 random in-range");
    end
    for (int n = 0; n < 20; n++) apply(1'b0, rnd64(), rnd64(), "R4 random word");
    // compare mode
    apply(1'b1, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, "R5 all equal");
    apply(1'b1, 64'h0000_0000_0000_0000, '1, "R5 all differ");
    apply(1'b1, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, "R5 partial");
    for (int n = 0; n < 40; n++) begin
      logic [63:0] a = rnd64();
      logic [63:0] b = a;
      for (int k = 0; k < 8; k++)
        if ($urandom_range(1) == 1) b[8*k +: 8] = a[8*k +: 8] ^ 8'($urandom_range(255, 1));
      apply(1'b1, a, b, "R5 random byte mix");
    end
    // same operands, both modes
    apply(1'b0, {8{8'd0}}, '1, "R6 gather select");
    apply(1'b1, {8{8'd0}}, '1, "R6 compare select");
    apply(1'b0, '1, '1, "R6 gather equal operands");
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule